// File: doc/BRIEF.md
# Opcode-Steered Dual-Read Register File

This block holds the sixteen 16-bit general registers of a small multi-cycle processor. It has two read ports and one write port. The instruction word that the sequencer presents splits into four 4-bit fields. The top field is the opcode. The three below it are register selectors, or the lowest field may be a small constant. The opcode decides which selector fields drive the two read ports. Any write goes to the register named by the first selector field, whatever the opcode.

The sequencer pulses `load_stb` in its register-load stage. Both selected registers are then captured into operand registers, which hold their values until the next pulse. In the register-store stage it pulses `store_stb`, and `wr_data` is written into the first-field register. For the two byte-load instructions the block also drives `byte_merged`. This is the first operand with one byte swapped for the 8-bit immediate, and the sequencer can send it back as write data. The instruction word must stay unchanged from the load pulse until the store pulse. The strobes are plain single-cycle controls: there is no handshake and nothing to back-pressure.

Top module: `opsel_regfile`

## Requirements
- R1: A synchronous active-high `rst` sets all sixteen registers and both operand outputs to zero.
- R2: For every opcode other than 9, B, D, E and F, a `load_stb` cycle captures into `op_a` the register named by bits 7:4 and into `op_b` the register named by bits 3:0. The outputs show the new values in the next cycle.
- R3: For opcodes 9, B, D, E and F (bits 15:12), a `load_stb` cycle captures the register named by bits 11:8 into `op_a` and the register named by bits 7:4 into `op_b`.
- R4: A `store_stb` cycle writes `wr_data` into the register named by bits 11:8, for any opcode. No other register changes.
- R5: Without `load_stb`, `op_a` and `op_b` keep their values, even when the instruction word or the register contents change.
- R6: Without `store_stb`, no register changes, whatever `wr_data` and the instruction word carry.
- R7: With opcode E, `byte_merged` is `op_a[15:8]` in bits 15:8 and instruction bits 7:0 in bits 7:0.
- R8: With opcode F, `byte_merged` is instruction bits 7:0 in bits 15:8 and `op_a[7:0]` in bits 7:0.
- R9: With any other opcode, `byte_merged` equals `op_a`.
- R10: When `load_stb` and `store_stb` are high in the same cycle, the operands capture the register values from before that write. The write still takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| instr | input | 16 | Instruction word: opcode 15:12, first field 11:8, second 7:4, third 3:0 |
| load_stb | input | 1 | Register-load stage strobe: capture operands |
| store_stb | input | 1 | Register-store stage strobe: write first-field register |
| wr_data | input | 16 | Data written on `store_stb` |
| op_a | output | 16 | First captured operand |
| op_b | output | 16 | Second captured operand |
| byte_merged | output | 16 | Byte-load merge result, or `op_a` |

## Verification
The bench writes a distinct value into every register, register 0 included. It then reads through each opcode class. A decoder that puts one of the five alternate opcodes in the wrong class would hand back a value shifted by one field. Store instructions whose second and third fields name other registers show whether a write lands anywhere but the first field. Loading and storing in the same cycle shows a bypass that leaks the new value early. The two byte merges are checked against operands whose two bytes differ, so swapped halves or a cleared kept byte show up at once. Finally, the operands are held while the instruction and write data change without strobes.

// File: rtl/regfile_pkg.sv
package regfile_pkg;

  localparam int OPC_W = 4;

  // Opcodes whose operands come from the first and second selector fields.
  localparam logic [OPC_W-1:0] OPC_STORE   = 4'h9;
  localparam logic [OPC_W-1:0] OPC_PORTOUT = 4'hB;
  localparam logic [OPC_W-1:0] OPC_BRANCH  = 4'hD;
  localparam logic [OPC_W-1:0] OPC_SETLO   = 4'hE;
  localparam logic [OPC_W-1:0] OPC_SETHI   = 4'hF;

  typedef enum logic [1:0] {
    MERGE_NONE = 2'd0,
    MERGE_LO   = 2'd1,
    MERGE_HI   = 2'd2
  } merge_kind_e;

  function automatic logic uses_upper_fields(input logic [OPC_W-1:0] opc);
    case (opc)
      OPC_STORE, OPC_PORTOUT, OPC_BRANCH, OPC_SETLO, OPC_SETHI: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic merge_kind_e merge_kind(input logic [OPC_W-1:0] opc);
    case (opc)
      OPC_SETLO: return MERGE_LO;
      OPC_SETHI: return MERGE_HI;
      default:   return MERGE_NONE;
    endcase
  endfunction

endpackage

// File: rtl/regfile_field_sel.sv
// Splits the instruction word and steers selector fields onto the read ports.
module regfile_field_sel
  import regfile_pkg::*;
#(
  parameter int ADDR_W  = 4,
  localparam int INSTR_W = OPC_W + 3 * ADDR_W
) (
  input  logic [INSTR_W-1:0] instr,
  output logic [ADDR_W-1:0]  rd_sel_a,
  output logic [ADDR_W-1:0]  rd_sel_b,
  output logic [ADDR_W-1:0]  wr_sel,
  output logic [OPC_W-1:0]   opcode
);

  logic [ADDR_W-1:0] fld1, fld2, fld3;

  always_comb begin
    opcode = instr[INSTR_W-1 -: OPC_W];
    fld1   = instr[3*ADDR_W-1 -: ADDR_W];
    fld2   = instr[2*ADDR_W-1 -: ADDR_W];
    fld3   = instr[ADDR_W-1:0];
    wr_sel = fld1;
    if (uses_upper_fields(opcode)) begin
      rd_sel_a = fld1;
      rd_sel_b = fld2;
    end else begin
      rd_sel_a = fld2;
      rd_sel_b = fld3;
    end
  end

endmodule

// File: rtl/regfile_bank.sv
// Register storage with two combinational read ports and one write port.
module regfile_bank #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 4,
  localparam int NREGS = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_sel_a,
  input  logic [ADDR_W-1:0] rd_sel_b,
  output logic [DATA_W-1:0] rd_data_a,
  output logic [DATA_W-1:0] rd_data_b
);

  logic [DATA_W-1:0] regs [NREGS];

  for (genvar gi = 0; gi < NREGS; gi++) begin : g_reg
    logic hit;
    assign hit = wr_en && (wr_sel == ADDR_W'(gi));
    always_ff @(posedge clk) begin
      if (rst) begin
        regs[gi] <= '0;
      end else if (hit) begin
        regs[gi] <= wr_data;
      end
    end
  end

  assign rd_data_a = regs[rd_sel_a];
  assign rd_data_b = regs[rd_sel_b];

endmodule

// File: rtl/regfile_byte_merge.sv
// Forms the byte-load result from the first operand and the 8-bit immediate.
module regfile_byte_merge
  import regfile_pkg::*;
#(
  parameter int DATA_W = 16,
  localparam int HALF_W = DATA_W / 2
) (
  input  logic [OPC_W-1:0]  opcode,
  input  logic [HALF_W-1:0] imm,
  input  logic [DATA_W-1:0] base,
  output logic [DATA_W-1:0] merged
);

  always_comb begin
    case (merge_kind(opcode))
      MERGE_LO: merged = {base[DATA_W-1:HALF_W], imm};
      MERGE_HI: merged = {imm, base[HALF_W-1:0]};
      default:  merged = base;
    endcase
  end

endmodule

// File: rtl/opsel_regfile.sv
module opsel_regfile
  import regfile_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 4,
  localparam int INSTR_W = OPC_W + 3 * ADDR_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [INSTR_W-1:0] instr,
  input  logic               load_stb,
  input  logic               store_stb,
  input  logic [DATA_W-1:0]  wr_data,
  output logic [DATA_W-1:0]  op_a,
  output logic [DATA_W-1:0]  op_b,
  output logic [DATA_W-1:0]  byte_merged
);

  localparam int HALF_W = DATA_W / 2;

  logic [ADDR_W-1:0] sel_a, sel_b, sel_w;
  logic [OPC_W-1:0]  opcode;
  logic [DATA_W-1:0] rd_a, rd_b;

  regfile_field_sel #(.ADDR_W(ADDR_W)) u_sel (
    .instr    (instr),
    .rd_sel_a (sel_a),
    .rd_sel_b (sel_b),
    .wr_sel   (sel_w),
    .opcode   (opcode)
  );

  regfile_bank #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_bank (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (store_stb),
    .wr_sel    (sel_w),
    .wr_data   (wr_data),
    .rd_sel_a  (sel_a),
    .rd_sel_b  (sel_b),
    .rd_data_a (rd_a),
    .rd_data_b (rd_b)
  );

  // Operand latches: reads before any same-cycle write lands.
  always_ff @(posedge clk) begin
    if (rst) begin
      op_a <= '0;
      op_b <= '0;
    end else if (load_stb) begin
      op_a <= rd_a;
      op_b <= rd_b;
    end
  end

  regfile_byte_merge #(.DATA_W(DATA_W)) u_merge (
    .opcode (opcode),
    .imm    (instr[HALF_W-1:0]),
    .base   (op_a),
    .merged (byte_merged)
  );

endmodule

// File: rtl/opsel_regfile_chk.sv
// Shadow-model checker bound to the register file.
module opsel_regfile_chk #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 4,
  localparam int INSTR_W = 4 + 3 * ADDR_W,
  localparam int NREGS = 1 << ADDR_W
) (
  input logic               clk,
  input logic               rst,
  input logic [INSTR_W-1:0] instr,
  input logic               load_stb,
  input logic               store_stb,
  input logic [DATA_W-1:0]  wr_data,
  input logic [DATA_W-1:0]  op_a,
  input logic [DATA_W-1:0]  op_b
);

  logic [DATA_W-1:0] shadow [NREGS];
  logic [3:0]        opc;
  logic [ADDR_W-1:0] f1, f2, f3;
  logic              alt;
  logic [DATA_W-1:0] exp_a, exp_b;

  assign opc = instr[INSTR_W-1 -: 4];
  assign f1  = instr[3*ADDR_W-1 -: ADDR_W];
  assign f2  = instr[2*ADDR_W-1 -: ADDR_W];
  assign f3  = instr[ADDR_W-1:0];
  assign alt = (opc == 4'h9) || (opc == 4'hB) || (opc >= 4'hD);
  assign exp_a = alt ? shadow[f1] : shadow[f2];
  assign exp_b = alt ? shadow[f2] : shadow[f3];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREGS; i++) shadow[i] <= '0;
    end else if (store_stb) begin
      shadow[f1] <= wr_data;
    end
  end

  AST_READ_LOWER_FIELDS: assert property (@(posedge clk) disable iff (rst)
    (load_stb && !alt) |=> (op_a == $past(exp_a) && op_b == $past(exp_b))); // R2

  AST_READ_UPPER_FIELDS: assert property (@(posedge clk) disable iff (rst)
    (load_stb && alt) |=> (op_a == $past(exp_a) && op_b == $past(exp_b))); // R3

  AST_OPERANDS_HELD: assert property (@(posedge clk) disable iff (rst)
    !load_stb |=> ($stable(op_a) && $stable(op_b))); // R5

  AST_LOAD_SEES_OLD: assert property (@(posedge clk) disable iff (rst)
    (load_stb && store_stb) |=> (op_a == $past(exp_a))); // R10

endmodule

bind opsel_regfile opsel_regfile_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .instr     (instr),
  .load_stb  (load_stb),
  .store_stb (store_stb),
  .wr_data   (wr_data),
  .op_a      (op_a),
  .op_b      (op_b)
);

// File: tb/opsel_regfile_test.sv
`timescale 1ns/1ps
module opsel_regfile_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] instr = '0;
  logic        load_stb = 1'b0;
  logic        store_stb = 1'b0;
  logic [15:0] wr_data = '0;
  logic [15:0] op_a, op_b, byte_merged;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  opsel_regfile uut (
    .clk (clk), .rst (rst), .instr (instr), .load_stb (load_stb),
    .store_stb (store_stb), .wr_data (wr_data), .op_a (op_a), .op_b (op_b),
    .byte_merged (byte_merged)
  );

  function automatic logic [15:0] pat(input int i);
    return 16'(i * 16'h1111) ^ 16'h5AC3;
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_store(input logic [15:0] ins, input logic [15:0] d);
    instr = ins; wr_data = d; store_stb = 1'b1;
    @(negedge clk);
    store_stb = 1'b0;
  endtask

  task automatic do_load(input logic [15:0] ins);
    instr = ins; load_stb = 1'b1;
    @(negedge clk);
    load_stb = 1'b0;
  endtask

  task automatic t_reset;
    check("R1", op_a, 16'h0);
    check("R1", op_b, 16'h0);
    do_load(16'h0_0_1_F);
    check("R1", op_a, 16'h0);
    check("R1", op_b, 16'h0);
  endtask

  task automatic t_fill;
    for (int i = 0; i < 16; i++) do_store({4'h0, 4'(i), 8'h00}, pat(i));
    for (int i = 0; i < 16; i += 2) begin
      do_load({4'h0, 4'h0, 4'(i), 4'(i + 1)});
      check("R4", op_a, pat(i));
      check("R4", op_b, pat(i + 1));
    end
  endtask

  task automatic t_normal;
    logic [3:0] ops [11] = '{4'h0, 4'h1, 4'h2, 4'h3, 4'h4, 4'h5, 4'h6, 4'h7, 4'h8, 4'hA, 4'hC};
    for (int k = 0; k < 11; k++) begin
      do_load({ops[k], 4'h3, 4'h5, 4'h9});
      check("R2", op_a, pat(5));
      check("R2", op_b, pat(9));
      check("R9", byte_merged, pat(5));
    end
  endtask

  task automatic t_alt;
    logic [3:0] ops [5] = '{4'h9, 4'hB, 4'hD, 4'hE, 4'hF};
    for (int k = 0; k < 5; k++) begin
      do_load({ops[k], 4'h3, 4'h5, 4'h9});
      check("R3", op_a, pat(3));
      check("R3", op_b, pat(5));
    end
  endtask

  task automatic t_merge;
    do_load(16'hE_7_C3);
    check("R7", byte_merged, {pat(7)[15:8], 8'hC3});
    do_load(16'hF_7_3C);
    check("R8", byte_merged, {8'h3C, pat(7)[7:0]});
    do_load(16'hE_0_00);
    check("R7", byte_merged, {pat(0)[15:8], 8'h00});
  endtask

  task automatic t_hold;
    do_load(16'h0_0_2_4);
    instr = 16'h0_0_6_8; wr_data = 16'hDEAD;
    repeat (3) @(negedge clk);
    check("R5", op_a, pat(2));
    check("R5", op_b, pat(4));
    do_store(16'h0_2_0_0, 16'hBEEF);
    check("R5", op_a, pat(2));
    instr = 16'h0_4_0_0; wr_data = 16'h1234;
    repeat (2) @(negedge clk);
    do_load(16'h0_0_4_6);
    check("R6", op_a, pat(4));
    check("R6", op_b, pat(6));
    do_load(16'h0_0_2_2);
    check("R4", op_a, 16'hBEEF);
  endtask

  task automatic t_target;
    do_store(16'h5_A_B_C, 16'h7E57);
    do_load(16'h0_0_B_C);
    check("R4", op_a, pat(11));
    check("R4", op_b, pat(12));
    do_load(16'h0_0_A_B);
    check("R4", op_a, 16'h7E57);
  endtask

  task automatic t_same_cycle;
    instr = 16'hD_6_7_0; wr_data = 16'hC0DE;
    load_stb = 1'b1; store_stb = 1'b1;
    @(negedge clk);
    load_stb = 1'b0; store_stb = 1'b0;
    check("R10", op_a, pat(6));
    check("R10", op_b, pat(7));
    do_load(16'hD_6_7_0);
    check("R10", op_a, 16'hC0DE);
  endtask

  initial begin
    #200000;
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_fill();
    t_normal();
    t_alt();
    t_merge();
    t_hold();
    t_target();
    t_same_cycle();
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule